// File: doc/BRIEF.md
# Dual-Width Register Bus Interface

This block is the slave side of a parallel register bus for a converter-style peripheral. Behind a 13-bit data bus with active-low chip select, read and write strobes it keeps a write-only 13-bit configuration word and a read-only 13-bit result word. The result word is loaded from a sequencer elsewhere in the chip. The bus runs either as a byte-wide port or as a full 13-bit port. Bit 12 of the configuration word picks which.

In byte mode, bit 7 of the low configuration byte acts as a pointer that sends the next write to the upper byte. The pointer clears itself once that upper byte is written. Results are read as two bytes, low byte first. In full mode every access moves the whole word in a single cycle.

The strobes are asynchronous to the system clock. They pass through synchronizers, and the write edge that captures data is chosen by a static strap. The block tells the sequencer when a command-bearing write has finished and when a complete result has been read out.

Top module: `dual_width_regif`

## Requirements
- R1: After reset the configuration word is 0, which means byte mode with the pointer clear. No data line is enabled, and neither completion pulse is active.
- R2: During a read (cs_n and rd_n both low), bus_oe[7:0] is all ones. bus_oe[12:8] is all ones only while configuration bit 12 is 1; otherwise it stays 0. Outside a read, bus_oe is 0.
- R3: In byte mode with the pointer (configuration bit 7) clear, a write loads bus_in[7:0] into configuration bits 7..0. bus_in[12:8] is ignored, bits 12..8 are kept, and wr_done does not pulse.
- R4: In byte mode with the pointer set, a write loads bus_in[4:0] into configuration bits 12..8. The same write clears bit 7 and pulses wr_done, so the next write goes to the low byte again.
- R5: In byte mode the first read drives result bits 7..0 on bus_out[7:0]. The second read drives result bits 12..8 on bus_out[4:0], with bus_out[7:5] copying result bit 12. rd_done pulses only after the rising RD edge that ends the second read.
- R6: In full mode a single write loads all 13 bits, always stores bit 7 as 0, and pulses wr_done. A single read drives all 13 result bits and pulses rd_done when RD rises.
- R7: With wr_fall_strap at 1, the data present at the falling WR edge is latched. With the strap at 0, the data present at the rising WR edge is latched.
- R8: Loading a new result through res_load returns the byte-read sequence to the low byte, and no rd_done is produced.
- R9: While cs_n is high, activity on WR and RD does not change the configuration word, does not enable the bus and does not pulse either completion signal.
- R10: wr_done and rd_done are each high for exactly one clock cycle per event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select (asynchronous) |
| rd_n | input | 1 | Active-low read strobe (asynchronous) |
| wr_n | input | 1 | Active-low write strobe (asynchronous) |
| wr_fall_strap | input | 1 | 1: latch on falling WR edge, 0: on rising WR edge |
| bus_in | input | 13 | Data lines as seen from the pads |
| bus_out | output | 13 | Data driven toward the pads |
| bus_oe | output | 13 | Per-line output enable for the pad drivers |
| res_load | input | 1 | Loads res_data into the result word |
| res_data | input | 13 | New result from the sequencer |
| cfg_q | output | 13 | Current configuration word |
| wr_done | output | 1 | One-cycle pulse: command-bearing write finished |
| rd_done | output | 1 | One-cycle pulse: full result read out |

## Verification
Properties embedded in the design check, on every cycle, that the completion pulses last one cycle. They also check that the byte pointer is clear whenever wr_done fires, that a low-byte write leaves the upper configuration bits untouched, that a byte-mode rd_done is always preceded by an upper-byte read, and that a result load resets the read sequence. The directed scenarios are needed for behaviour visible only at the pads: byte ordering and sign filling on reads, the tri-state pattern in each width, edge selection by the strap, and chip-select gating.

// File: rtl/dwb_pkg.sv
package dwb_pkg;

   // synchronized view of one asynchronous strobe
   typedef struct packed {
      logic level;   // synchronized active level
      logic rise;    // became active
      logic fall;    // became inactive
   } dwb_edge_t;

   localparam int N_STROBES = 2;
   localparam int IDX_WR    = 0;
   localparam int IDX_RD    = 1;

endpackage

// File: rtl/dwb_sync_edge.sv
module dwb_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              async_in,
   output dwb_pkg::dwb_edge_t ev
);

   initial begin
      assert (STAGES >= 2) else $fatal(1, "dwb_sync_edge: STAGES must be at least 2");
   end

   // chain[STAGES-1] is the synchronized level, chain[STAGES] its previous value
   logic [STAGES:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-1:0], async_in};
   end

   always_comb begin
      ev.level = chain[STAGES-1];
      ev.rise  = chain[STAGES-1] & ~chain[STAGES];
      ev.fall  = ~chain[STAGES-1] & chain[STAGES];
   end

endmodule

// File: rtl/dwb_cfg_reg.sv
module dwb_cfg_reg #(
   parameter int DATA_W = 13,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_ev,
   input  logic [DATA_W-1:0] bus_q,
   output logic [DATA_W-1:0] cfg_q,
   output logic              wr_done
);

   localparam int WIDE_BIT = DATA_W - 1;
   localparam int PTR_BIT  = BYTE_W - 1;
   localparam int UP_W     = DATA_W - BYTE_W;

   logic [DATA_W-1:0] cfg_nx;
   logic              done_nx;

   always_comb begin
      cfg_nx  = cfg_q;
      done_nx = 1'b0;
      if (wr_ev) begin
         if (cfg_q[WIDE_BIT]) begin
            cfg_nx          = bus_q;
            cfg_nx[PTR_BIT] = 1'b0;
            done_nx         = 1'b1;
         end else if (cfg_q[PTR_BIT]) begin
            cfg_nx[DATA_W-1:BYTE_W] = bus_q[UP_W-1:0];
            cfg_nx[PTR_BIT]         = 1'b0;
            done_nx                 = 1'b1;
         end else begin
            cfg_nx[BYTE_W-1:0] = bus_q[BYTE_W-1:0];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q   <= '0;
         wr_done <= 1'b0;
      end else begin
         cfg_q   <= cfg_nx;
         wr_done <= done_nx;
      end
   end

   // R10: completion is a single-cycle pulse
   p_wr_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_done |=> !wr_done);

   // R4: the pointer is never left set by a completing write
   p_ptr_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_done |-> !cfg_q[PTR_BIT]);

   // R3: low-byte write keeps the upper byte and reports nothing
   p_low_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ev && !cfg_q[WIDE_BIT] && !cfg_q[PTR_BIT])
      |=> ($stable(cfg_q[DATA_W-1:BYTE_W]) && !wr_done));

endmodule

// File: rtl/dwb_rd_path.sv
module dwb_rd_path #(
   parameter int DATA_W    = 13,
   parameter int BYTE_W    = 8,
   parameter bit SIGN_FILL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_ev,
   input  logic              rd_on,
   input  logic              wide,
   input  logic              res_load,
   input  logic [DATA_W-1:0] res_data,
   output logic [DATA_W-1:0] bus_out,
   output logic [DATA_W-1:0] bus_oe,
   output logic              rd_done
);

   localparam int UP_W   = DATA_W - BYTE_W;
   localparam int FILL_W = BYTE_W - UP_W;

   logic [DATA_W-1:0] result;
   logic              hi_sel;
   logic [BYTE_W-1:0] up_byte;
   logic [BYTE_W-1:0] sel_byte;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result  <= '0;
         hi_sel  <= 1'b0;
         rd_done <= 1'b0;
      end else begin
         rd_done <= 1'b0;
         if (res_load) begin
            result <= res_data;
            hi_sel <= 1'b0;
         end else if (rd_ev) begin
            if (wide || hi_sel) begin
               hi_sel  <= 1'b0;
               rd_done <= 1'b1;
            end else begin
               hi_sel  <= 1'b1;
            end
         end
      end
   end

   // upper byte filler: sign copy or zeros
   generate
      if (FILL_W == 0) begin : g_nofill
         assign up_byte = result[DATA_W-1:BYTE_W];
      end else if (SIGN_FILL) begin : g_sign
         assign up_byte = {{FILL_W{result[DATA_W-1]}}, result[DATA_W-1:BYTE_W]};
      end else begin : g_zero
         assign up_byte = {{FILL_W{1'b0}}, result[DATA_W-1:BYTE_W]};
      end
   endgenerate

   always_comb begin
      sel_byte = hi_sel ? up_byte : result[BYTE_W-1:0];
      bus_out  = wide ? result : {{UP_W{1'b0}}, sel_byte};
      bus_oe   = {{UP_W{rd_on & wide}}, {BYTE_W{rd_on}}};
   end

   // R10: completion is a single-cycle pulse
   p_rd_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rd_done |=> !rd_done);

   // R8: a new result restarts the byte sequence
   p_seq_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
      res_load |=> !hi_sel);

   // R5: byte-mode completion follows an upper-byte read
   p_narrow_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_done && !wide) |-> $past(hi_sel));

endmodule

// File: rtl/dual_width_regif.sv
module dual_width_regif #(
   parameter int DATA_W      = 13,
   parameter int BYTE_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit SIGN_FILL   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              rd_n,
   input  logic              wr_n,
   input  logic              wr_fall_strap,
   input  logic [DATA_W-1:0] bus_in,
   output logic [DATA_W-1:0] bus_out,
   output logic [DATA_W-1:0] bus_oe,
   input  logic              res_load,
   input  logic [DATA_W-1:0] res_data,
   output logic [DATA_W-1:0] cfg_q,
   output logic              wr_done,
   output logic              rd_done
);

   import dwb_pkg::*;

   localparam int WIDE_BIT = DATA_W - 1;

   initial begin
      assert (DATA_W > BYTE_W)     else $fatal(1, "dual_width_regif: DATA_W must exceed BYTE_W");
      assert (DATA_W <= 2*BYTE_W)  else $fatal(1, "dual_width_regif: DATA_W must fit in two bytes");
      assert (BYTE_W >= 2)         else $fatal(1, "dual_width_regif: BYTE_W too small");
   end

   logic [N_STROBES-1:0] strobe_raw;
   dwb_edge_t            strobe_ev [N_STROBES];
   logic [DATA_W-1:0]    bus_q;
   logic                 wr_ev;
   logic                 rd_ev;
   logic                 rd_on;

   assign strobe_raw[IDX_WR] = ~cs_n & ~wr_n;
   assign strobe_raw[IDX_RD] = ~cs_n & ~rd_n;
   assign rd_on              = ~cs_n & ~rd_n;

   generate
      for (genvar g = 0; g < N_STROBES; g++) begin : g_sync
         dwb_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
            .clk      (clk),
            .rst_n    (rst_n),
            .async_in (strobe_raw[g]),
            .ev       (strobe_ev[g])
         );
      end
   endgenerate

   // registered bus sample, read out on the chosen edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bus_q <= '0;
      else        bus_q <= bus_in;
   end

   assign wr_ev = wr_fall_strap ? strobe_ev[IDX_WR].rise : strobe_ev[IDX_WR].fall;
   assign rd_ev = strobe_ev[IDX_RD].fall;

   dwb_cfg_reg #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_ev   (wr_ev),
      .bus_q   (bus_q),
      .cfg_q   (cfg_q),
      .wr_done (wr_done)
   );

   dwb_rd_path #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .SIGN_FILL(SIGN_FILL)) u_rd (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_ev    (rd_ev),
      .rd_on    (rd_on),
      .wide     (cfg_q[WIDE_BIT]),
      .res_load (res_load),
      .res_data (res_data),
      .bus_out  (bus_out),
      .bus_oe   (bus_oe),
      .rd_done  (rd_done)
   );

   // R9: a deselected write strobe produces no completion
   p_cs_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!strobe_ev[IDX_WR].level && !strobe_ev[IDX_WR].fall && !strobe_ev[IDX_WR].rise) |=> !wr_done);

endmodule

// File: tb/dual_width_regif_test.sv
module dual_width_regif_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
   logic        wr_fall_strap = 1'b1;
   logic [12:0] bus_in = '0;
   logic [12:0] bus_out, bus_oe;
   logic        res_load = 1'b0;
   logic [12:0] res_data = '0;
   logic [12:0] cfg_q;
   logic        wr_done, rd_done;

   int n_tests = 0, n_fail = 0;
   int wr_cnt = 0, wr_hi = 0, rd_cnt = 0, rd_hi = 0;
   logic wr_prev = 1'b0, rd_prev = 1'b0;
   bit finished = 0;

   always #10 clk = ~clk;

   dual_width_regif uut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
      .wr_fall_strap(wr_fall_strap), .bus_in(bus_in), .bus_out(bus_out),
      .bus_oe(bus_oe), .res_load(res_load), .res_data(res_data),
      .cfg_q(cfg_q), .wr_done(wr_done), .rd_done(rd_done)
   );

   always @(posedge clk) begin
      if (wr_done) wr_hi++;
      if (wr_done && !wr_prev) wr_cnt++;
      if (rd_done) rd_hi++;
      if (rd_done && !rd_prev) rd_cnt++;
      wr_prev <= wr_done;
      rd_prev <= rd_done;
   end

   task automatic check(input string req, input logic [12:0] act, input logic [12:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [12:0] a, input logic [12:0] b);
      @(negedge clk); bus_in = a; cs_n = 1'b0;
      repeat (2) @(negedge clk); wr_n = 1'b0;
      repeat (5) @(negedge clk); bus_in = b;
      repeat (5) @(negedge clk); wr_n = 1'b1;
      repeat (5) @(negedge clk); cs_n = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic bus_read(output logic [12:0] d, output logic [12:0] oe);
      @(negedge clk); cs_n = 1'b0; rd_n = 1'b0;
      repeat (3) @(negedge clk);
      d = bus_out; oe = bus_oe;
      rd_n = 1'b1;
      repeat (5) @(negedge clk); cs_n = 1'b1;
      repeat (3) @(negedge clk);
   endtask

   task automatic load_result(input logic [12:0] v);
      @(negedge clk); res_data = v; res_load = 1'b1;
      @(negedge clk); res_load = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_reset();
      check("R1 cfg", cfg_q, 13'h0000);
      check("R1 oe", bus_oe, 13'h0000);
      check("R1 pulses", {11'd0, wr_done, rd_done}, 13'h0000);
   endtask

   task automatic t_byte_low();
      int w0 = wr_cnt;
      bus_write(13'h005A, 13'h005A);
      check("R3 low write", cfg_q, 13'h005A);
      bus_write(13'h0033, 13'h0033);
      check("R3 stays low", cfg_q, 13'h0033);
      check("R3 no wr_done", 13'(wr_cnt - w0), 13'd0);
   endtask

   task automatic t_byte_pair();
      int w0 = wr_cnt;
      bus_write(13'h00B3, 13'h00B3);
      check("R4 ptr set", cfg_q, 13'h00B3);
      check("R4 no early done", 13'(wr_cnt - w0), 13'd0);
      bus_write(13'h0005, 13'h0005);
      check("R4 upper byte", cfg_q, 13'h0533);
      check("R4 wr_done", 13'(wr_cnt - w0), 13'd1);
      bus_write(13'h1F44, 13'h1F44);
      check("R3 back to low, upper lines ignored", cfg_q, 13'h0544);
   endtask

   task automatic t_byte_read();
      logic [12:0] d, oe;
      int r0 = rd_cnt;
      load_result(13'h1A5C);
      bus_read(d, oe);
      check("R5 low byte", d, 13'h005C);
      check("R2 narrow oe", oe, 13'h00FF);
      check("R5 no done after first", 13'(rd_cnt - r0), 13'd0);
      bus_read(d, oe);
      check("R5 upper byte sign filled", d, 13'h00FA);
      check("R5 done after second", 13'(rd_cnt - r0), 13'd1);
   endtask

   task automatic t_cs_ignore();
      int w0 = wr_cnt, r0 = rd_cnt;
      logic [12:0] oe;
      @(negedge clk); bus_in = 13'h00FF;
      wr_n = 1'b0; repeat (5) @(negedge clk);
      wr_n = 1'b1; repeat (5) @(negedge clk);
      rd_n = 1'b0; repeat (3) @(negedge clk);
      oe = bus_oe;
      rd_n = 1'b1; repeat (6) @(negedge clk);
      check("R9 cfg kept", cfg_q, 13'h0544);
      check("R9 oe off", oe, 13'h0000);
      check("R9 no pulses", 13'((wr_cnt - w0) + (rd_cnt - r0)), 13'd0);
   endtask

   task automatic t_go_wide();
      int w0 = wr_cnt;
      bus_write(13'h0080, 13'h0080);
      check("R4 pointer write", cfg_q, 13'h0580);
      bus_write(13'h0010, 13'h0010);
      check("R4 width bit set", cfg_q, 13'h1000);
      check("R4 wr_done", 13'(wr_cnt - w0), 13'd1);
   endtask

   task automatic t_wide();
      logic [12:0] d, oe;
      int w0 = wr_cnt, r0 = rd_cnt;
      bus_write(13'h1ABC, 13'h1ABC);
      check("R6 full write bit7 cleared", cfg_q, 13'h1A3C);
      bus_write(13'h1234, 13'h1234);
      check("R6 full write again", cfg_q, 13'h1234);
      check("R6 wr_done each write", 13'(wr_cnt - w0), 13'd2);
      load_result(13'h0123);
      bus_read(d, oe);
      check("R6 full read", d, 13'h0123);
      check("R2 wide oe", oe, 13'h1FFF);
      check("R6 rd_done", 13'(rd_cnt - r0), 13'd1);
   endtask

   task automatic t_strap();
      wr_fall_strap = 1'b0;
      bus_write(13'h1111, 13'h1222);
      check("R7 rising edge data", cfg_q, 13'h1222);
      wr_fall_strap = 1'b1;
      bus_write(13'h1333, 13'h1444);
      check("R7 falling edge data", cfg_q, 13'h1333);
   endtask

   task automatic t_seq_restart();
      logic [12:0] d, oe;
      int r0;
      bus_write(13'h0000, 13'h0000);
      check("R6 back to byte mode", cfg_q, 13'h0000);
      load_result(13'h0ABC);
      r0 = rd_cnt;
      bus_read(d, oe);
      check("R8 first low byte", d, 13'h00BC);
      load_result(13'h0456);
      bus_read(d, oe);
      check("R8 restarted at low byte", d, 13'h0056);
      check("R8 no rd_done", 13'(rd_cnt - r0), 13'd0);
      bus_read(d, oe);
      check("R8 then upper byte", d, 13'h0004);
      check("R8 done after pair", 13'(rd_cnt - r0), 13'd1);
   endtask

   task automatic t_pulses();
      check("R10 wr_done width", 13'(wr_hi), 13'(wr_cnt));
      check("R10 rd_done width", 13'(rd_hi), 13'(rd_cnt));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      t_reset();
      t_byte_low();
      t_byte_pair();
      t_byte_read();
      t_cs_ignore();
      t_go_wide();
      t_wide();
      t_strap();
      t_seq_restart();
      t_pulses();
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule